// File: doc/BRIEF.md
# Link Integrity Monitor with LED Status

This block watches the health of an idle 10 Mb/s twisted-pair link and reports it on a link LED. While the local transmitter is quiet, it sends a single-cycle, unipolar link-test pulse at a fixed interval. It measures the high time of every pulse on the receive line. A pulse whose width falls inside a narrow window counts as a link beat from the far end. A receive-valid indication from the squelch logic is also taken as proof that the link works.

The LED pin is modelled as an output enable plus a data bit, which gives three line states. With the enable off, the pin floats and the LED is dark, which means the link has failed. With the enable on and the data low, the LED is lit steadily: beats arrive but no data does. With both high, the LED is dark for a stretched interval each time a packet starts, so traffic shows as a blink. The link is declared failed when no beat and no receive activity have been seen for a set timeout.

There are three state machines. The transmit pulser has the states TP_BUSY, TP_COUNT and TP_FIRE. It moves BUSY→COUNT when transmit-enable drops, COUNT→FIRE when the interval expires, FIRE→COUNT after one cycle, and from any state to BUSY while transmit-enable is high. The receive qualifier has the states RQ_LOW, RQ_HIGH and RQ_LONG. It moves LOW→HIGH on a rising level, HIGH→LOW on a falling level (a beat if the width is in range), HIGH→LONG once the width passes the maximum, and LONG→LOW when the level falls. The LED state machine has the states LK_DOWN, LK_IDLE and LK_BLINK, with these transitions:
- acquire: DOWN→IDLE on a beat or a receive-valid level.
- activity: any state→BLINK on a receive-valid rising edge.
- retrigger: BLINK→BLINK on a new rising edge, which restarts the stretch.
- blink-done: BLINK→IDLE when the stretch ends.
- timeout: IDLE or BLINK→DOWN when the silence timer expires.

Top module: `link_beat_monitor`

## Requirements
- R1: While reset is held, and right after it, `led_oe`, `led_drv` and `link_pulse` are all 0, whatever `tx_en` does.
- R2: No link pulse is issued while the transmitter is busy. If `tx_en` is sampled high at a clock edge, `link_pulse` is 0 in the next cycle.
- R3: While `tx_en` stays low, `link_pulse` is high for exactly one cycle. Successive pulses start exactly TX_INTERVAL cycles apart, and the first comes about TX_INTERVAL cycles (±1) after `tx_en` falls.
- R4: A receive pulse that is sampled high for at least MIN_W and at most MAX_W consecutive cycles is a valid beat. From the failed state, a beat turns the LED to link-good idle (`led_oe`=1, `led_drv`=0).
- R5: A receive pulse that is high for more than MAX_W cycles is not a beat. It leaves a failed link failed and an idle link idle.
- R6: If FAIL_LIMIT cycles pass with no valid beat and no `rx_valid`, the link is declared failed: `led_oe`=0, `led_drv`=0. It is not declared failed earlier.
- R7: `rx_valid` held high counts as continuous proof of link and keeps the link up for as long as it is held. The silence timeout runs from the last cycle it was high.
- R8: A rising edge of `rx_valid` sets `led_oe`=1 and `led_drv`=1 from the next cycle, for BLINK_LEN cycles, and then returns to idle. This also brings a failed link up.
- R9: Holding `rx_valid` high gives a single blink. After the stretch the LED stays steadily low.
- R10: A new rising edge of `rx_valid` during a blink restarts the full stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Local transmitter busy; suppresses link pulses |
| rx_level | input | 1 | Digitised receive-line pulse level |
| rx_valid | input | 1 | Receive channel open, from the squelch logic |
| link_pulse | output | 1 | One-cycle request to drive a link-test pulse |
| led_oe | output | 1 | LED pin output enable (0 = high impedance, link failed) |
| led_drv | output | 1 | LED pin data when enabled (0 = steady on, 1 = blink off) |

## Verification
The bench sends pulses one, two, three, four and five cycles wide. A qualifier that is off by one in its width window would either bring a dead link up on a data-length pulse or ignore a genuine beat. It probes the silence timeout just before and just after its limit, catching a timer that does not restart on a beat or on a held `rx_valid`, or that counts the wrong span. It holds `rx_valid` for longer than the timeout, so a design that blinks on the level instead of the edge, or that lets the link drop during a long packet, is exposed. It also retriggers a blink halfway through, and it measures the exact spacing of link pulses and checks that none appear while transmitting or in reset.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    typedef enum logic [1:0] {
        TP_BUSY  = 2'd0,
        TP_COUNT = 2'd1,
        TP_FIRE  = 2'd2
    } tp_state_e;

    typedef enum logic [1:0] {
        RQ_LOW  = 2'd0,
        RQ_HIGH = 2'd1,
        RQ_LONG = 2'd2
    } rq_state_e;

    typedef enum logic [1:0] {
        LK_DOWN  = 2'd0,
        LK_IDLE  = 2'd1,
        LK_BLINK = 2'd2
    } lk_state_e;

endpackage

// File: rtl/lbm_tx_pulser.sv
module lbm_tx_pulser
    import lbm_pkg::*;
#(
    parameter int unsigned INTERVAL = 160000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic pulse
);
    localparam int unsigned CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 2);

    tp_state_e     state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TP_BUSY;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (tx_en) begin
            nxt     = TP_BUSY;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                TP_BUSY: begin
                    nxt     = TP_COUNT;
                    cnt_nxt = '0;
                end
                TP_COUNT: begin
                    if (cnt == LAST) begin
                        nxt     = TP_FIRE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                TP_FIRE: begin
                    nxt     = TP_COUNT;
                    cnt_nxt = '0;
                end
                default: nxt = TP_BUSY;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            TP_FIRE: pulse = 1'b1;
            default: pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/lbm_rx_qualifier.sv
module lbm_rx_qualifier
    import lbm_pkg::*;
#(
    parameter int unsigned MIN_W = 1,
    parameter int unsigned MAX_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_level,
    output logic beat
);
    localparam int unsigned CW = $clog2(MAX_W + 1);
    localparam logic [CW-1:0] WMIN = CW'(MIN_W);
    localparam logic [CW-1:0] WMAX = CW'(MAX_W);

    rq_state_e     state, nxt;
    logic [CW-1:0] width, width_nxt;
    logic          lvl_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RQ_LOW;
            width <= '0;
            lvl_q <= 1'b0;
        end else begin
            state <= nxt;
            width <= width_nxt;
            lvl_q <= rx_level;
        end
    end

    // next state
    always_comb begin
        nxt       = state;
        width_nxt = width;
        unique case (state)
            RQ_LOW: begin
                if (lvl_q) begin
                    nxt       = RQ_HIGH;
                    width_nxt = CW'(1);
                end
            end
            RQ_HIGH: begin
                if (!lvl_q) begin
                    nxt = RQ_LOW;
                end else if (width == WMAX) begin
                    nxt = RQ_LONG;
                end else begin
                    width_nxt = width + 1'b1;
                end
            end
            RQ_LONG: begin
                if (!lvl_q) nxt = RQ_LOW;
            end
            default: nxt = RQ_LOW;
        endcase
    end

    // outputs: one-cycle beat strobe on the falling edge of an in-window pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat <= 1'b0;
        end else begin
            unique case (state)
                RQ_HIGH: beat <= !lvl_q && (width >= WMIN);
                default: beat <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lbm_silence_timer.sv
module lbm_silence_timer #(
    parameter int unsigned LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic rx_valid,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // counts cycles without evidence of link, saturating at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (beat || rx_valid) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == TOP);

endmodule

// File: rtl/lbm_led_fsm.sv
module lbm_led_fsm
    import lbm_pkg::*;
#(
    parameter int unsigned BLINK_LEN = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic rx_valid,
    input  logic expired,
    output logic led_oe,
    output logic led_drv
);
    localparam int unsigned CW = $clog2(BLINK_LEN + 1);
    localparam logic [CW-1:0] BLAST = CW'(BLINK_LEN - 1);

    lk_state_e     state, nxt;
    logic [CW-1:0] bcnt;
    logic          rv_q;
    logic          rise;
    logic          restart;
    logic          silent;

    assign rise   = rx_valid && !rv_q;
    assign silent = expired && !rx_valid && !beat;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LK_DOWN;
            rv_q  <= 1'b0;
            bcnt  <= '0;
        end else begin
            state <= nxt;
            rv_q  <= rx_valid;
            if (restart) begin
                bcnt <= '0;
            end else if (state == LK_BLINK) begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    // next state: activity, acquire, retrigger, blink-done, timeout
    always_comb begin
        nxt     = state;
        restart = 1'b0;
        unique case (state)
            LK_DOWN: begin
                if (rise) begin
                    nxt     = LK_BLINK;
                    restart = 1'b1;
                end else if (beat || rx_valid) begin
                    nxt = LK_IDLE;
                end
            end
            LK_IDLE: begin
                if (rise) begin
                    nxt     = LK_BLINK;
                    restart = 1'b1;
                end else if (silent) begin
                    nxt = LK_DOWN;
                end
            end
            LK_BLINK: begin
                if (rise) begin
                    restart = 1'b1;
                end else if (silent) begin
                    nxt = LK_DOWN;
                end else if (bcnt == BLAST) begin
                    nxt = LK_IDLE;
                end
            end
            default: nxt = LK_DOWN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            LK_IDLE:  begin led_oe = 1'b1; led_drv = 1'b0; end
            LK_BLINK: begin led_oe = 1'b1; led_drv = 1'b1; end
            default:  begin led_oe = 1'b0; led_drv = 1'b0; end
        endcase
    end

endmodule

// File: rtl/link_beat_monitor.sv
module link_beat_monitor #(
    parameter int unsigned TX_INTERVAL = 160000,
    parameter int unsigned FAIL_LIMIT  = 1000000,
    parameter int unsigned BLINK_LEN   = 500000,
    parameter int unsigned MIN_W       = 1,
    parameter int unsigned MAX_W       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic rx_level,
    input  logic rx_valid,
    output logic link_pulse,
    output logic led_oe,
    output logic led_drv
);
    logic beat;
    logic expired;

    lbm_tx_pulser #(
        .INTERVAL (TX_INTERVAL)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tx_en (tx_en),
        .pulse (link_pulse)
    );

    lbm_rx_qualifier #(
        .MIN_W (MIN_W),
        .MAX_W (MAX_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_level),
        .beat     (beat)
    );

    lbm_silence_timer #(
        .LIMIT (FAIL_LIMIT)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .rx_valid (rx_valid),
        .expired  (expired)
    );

    lbm_led_fsm #(
        .BLINK_LEN (BLINK_LEN)
    ) u_led (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .rx_valid (rx_valid),
        .expired  (expired),
        .led_oe   (led_oe),
        .led_drv  (led_drv)
    );

endmodule

// File: rtl/lbm_checker.sv
module lbm_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic rx_valid,
    input logic link_pulse,
    input logic led_oe,
    input logic led_drv
);

    assert_no_pulse_while_busy_R2: assert property (
        @(posedge clk) disable iff (!rst_n) tx_en |=> !link_pulse);

    assert_single_cycle_pulse_R3: assert property (
        @(posedge clk) disable iff (!rst_n) link_pulse |=> !link_pulse);

    assert_blink_on_edge_R8: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(rx_valid) |=> (led_oe && led_drv));

    assert_blink_only_enabled_R8: assert property (
        @(posedge clk) disable iff (!rst_n) led_drv |-> led_oe);

    assert_valid_keeps_link_R7: assert property (
        @(posedge clk) disable iff (!rst_n) rx_valid |=> led_oe);

    assert_fail_needs_silence_R6: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(led_oe) |-> !$past(rx_valid));

endmodule

bind link_beat_monitor lbm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .rx_valid   (rx_valid),
    .link_pulse (link_pulse),
    .led_oe     (led_oe),
    .led_drv    (led_drv)
);

// File: tb/sim_link_beat_monitor.sv
module sim_link_beat_monitor;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int TXI  = 20;
    localparam int FAIL = 80;
    localparam int BL   = 16;
    localparam int NV   = 8;

    // vector: rx pulse width, rx_valid cycles, wait cycles, expected oe, expected drv
    localparam int VEC [0:NV-1][0:4] = '{
        '{3, 0,   6, 0, 0},
        '{5, 0,   6, 0, 0},
        '{1, 0,   6, 1, 0},
        '{2, 0,   6, 1, 0},
        '{0, 1,   3, 1, 1},
        '{0, 0,  20, 1, 0},
        '{4, 0,   6, 1, 0},
        '{0, 0, 100, 0, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic rx_level = 1'b0;
    logic rx_valid = 1'b0;
    logic link_pulse, led_oe, led_drv;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    link_beat_monitor #(
        .TX_INTERVAL (TXI),
        .FAIL_LIMIT  (FAIL),
        .BLINK_LEN   (BL),
        .MIN_W       (1),
        .MAX_W       (2)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .rx_level   (rx_level),
        .rx_valid   (rx_valid),
        .link_pulse (link_pulse),
        .led_oe     (led_oe),
        .led_drv    (led_drv)
    );

    function automatic string vreq(int i);
        case (i)
            0, 1, 6: return "R5";
            2, 3:    return "R4";
            4, 5:    return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic led_is(string req, string what, bit e_oe, bit e_drv);
        int act;
        int exp;
        act = {30'd0, led_oe, led_drv};
        exp = {30'd0, e_oe, e_drv};
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic rx_pulse(int w);
        if (w > 0) begin
            rx_level = 1'b1;
            tick(w);
            rx_level = 1'b0;
        end
    endtask

    task automatic valid_burst(int n);
        if (n > 0) begin
            rx_valid = 1'b1;
            tick(n);
            rx_valid = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hits;
        int first;
        int last;
        int gap_bad;
        int dbl;
        bit prev;

        // R1: reset held with transmitter idle; no pulse, LED floating
        hits = 0;
        for (int i = 0; i < TXI + 10; i++) begin
            tick(1);
            if (link_pulse) hits++;
        end
        chk(hits == 0, "R1", "pulses during reset", hits, 0);
        led_is("R1", "led during reset", 1'b0, 1'b0);
        tx_en = 1'b1;
        tick(1);
        rst_n = 1'b1;
        tick(2);
        led_is("R1", "led after reset", 1'b0, 1'b0);
        chk(link_pulse == 1'b0, "R1", "pulse after reset", int'(link_pulse), 0);

        // table walk: receive qualification, blink and timeout
        for (int v = 0; v < NV; v++) begin
            rx_pulse(VEC[v][0]);
            valid_burst(VEC[v][1]);
            tick(VEC[v][2]);
            led_is(vreq(v), $sformatf("vector %0d", v), VEC[v][3][0], VEC[v][4][0]);
        end

        // R6: timeout edges after a single beat
        rx_pulse(1);
        tick(6);
        led_is("R4", "beat from failed link", 1'b1, 1'b0);
        tick(FAIL - 16);
        led_is("R6", "still up before limit", 1'b1, 1'b0);
        tick(20);
        led_is("R6", "down after limit", 1'b0, 1'b0);

        // R7 / R9: long packet keeps the link up and blinks once
        rx_valid = 1'b1;
        tick(3);
        led_is("R8", "blink brings link up", 1'b1, 1'b1);
        tick(3 * FAIL);
        led_is("R9", "held valid steady low", 1'b1, 1'b0);
        rx_valid = 1'b0;
        tick(FAIL - 10);
        led_is("R7", "timer restarted at valid drop", 1'b1, 1'b0);
        tick(20);
        led_is("R7", "down after valid silence", 1'b0, 1'b0);

        // R10: retrigger during a blink
        rx_pulse(1);
        tick(6);
        valid_burst(1);
        tick(8);
        valid_burst(1);
        tick(11);
        led_is("R10", "stretch restarted", 1'b1, 1'b1);
        tick(8);
        led_is("R10", "restarted stretch ends", 1'b1, 1'b0);

        // R3: link pulse spacing while transmitter idle
        tx_en = 1'b0;
        hits = 0; first = -1; last = -1; gap_bad = 0; dbl = 0; prev = 1'b0;
        for (int i = 1; i <= 4 * TXI + 5; i++) begin
            tick(1);
            if (link_pulse) begin
                if (prev) dbl++;
                hits++;
                if (first < 0) first = i;
                if (last >= 0 && !prev && (i - last) != TXI) gap_bad++;
                if (!prev) last = i;
            end
            prev = link_pulse;
        end
        chk(first >= TXI - 1 && first <= TXI + 1, "R3", "first pulse cycle", first, TXI);
        chk(gap_bad == 0, "R3", "pulse spacing errors", gap_bad, 0);
        chk(dbl == 0, "R3", "multi-cycle pulses", dbl, 0);
        chk(hits == 4, "R3", "pulse count", hits, 4);

        // R2: no pulses while transmitting
        tx_en = 1'b1;
        tick(1);
        hits = 0;
        for (int i = 0; i < 3 * TXI; i++) begin
            tick(1);
            if (link_pulse) hits++;
        end
        chk(hits == 0, "R2", "pulses while busy", hits, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule